// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a register-mapped real-time counter for a simple 32-bit register bus. The bus has an address, a write enable, write data and a combinational read data path. The block keeps a free-running count that advances on a one-cycle tick from an external 1 Hz prescaler. Software can replace the count through a load register. The block also holds a match value and compares it with the count modulo 2^32. When the two become equal, a sticky raw status bit is set. The interrupt line is that bit gated by a one-bit mask.

Software first programs the match value, then clears any stale status and enables the mask. It then waits for the interrupt and acknowledges it by writing the clear register. The control register always reads as enabled. An identification region at the top of the 4 KiB window returns one byte per word. Reads of the clear register and of any unmapped word return zero.

Top module: `sec_counter_alarm`

## Requirements
- R1: Word 0x00 reads the current count. The count resets to 0, advances by one in the cycle after each `tick` pulse, and wraps from 0xFFFFFFFF to 0.
- R2: A write to word 0x08 (load) replaces the count with the written data. The load wins over a `tick` in the same cycle. Word 0x08 reads back the last value loaded, which is 0 after reset.
- R3: Word 0x04 holds the 32-bit match value. It resets to 0 and reads back what was written.
- R4: Bit 0 of word 0x14 (raw status) is set in the cycle in which the count becomes equal to the match. This includes a load that makes them equal. The bit then stays set through later ticks until a clear write.
- R5: Matching is modulo 2^32, so a match value numerically below the count fires after the count wraps.
- R6: Writing a match value equal to the current count sets raw status at once, in the cycle after the write.
- R7: A write to word 0x10 (mask) keeps only data bit 0. `irq` and bit 0 of word 0x18 (masked status) both equal raw AND mask. They follow a mask write in the next cycle.
- R8: Any write to word 0x1C clears raw status, whatever the data. A clear beats a match that happens in the same cycle.
- R9: Word 0x0C (control) always reads 1, and writes to it change nothing.
- R10: A read in 0xFE0 to 0xFFF returns byte k of parameter `ID_BYTES` (byte 0 is the least significant), zero-extended. Here k = (address - 0xFE0) >> 2.
- R11: Address bits [1:0] are ignored. Reads of word 0x1C and of every unmapped word return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 Hz advance pulse |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt, raw status AND mask |

## Verification
A wrong count shows at word 0x00 in the cycle after the tick or load that produced it. A wrong compare shows up differently depending on its direction:
- A compare that misses leaves raw status low after the count reaches the match.
- A compare that fires early or late moves the rising edge of raw status off the tick that made the values equal.

The sweeps step one tick at a time around each match distance, both across the wrap and away from it, so either fault is seen within one cycle. A lost mask or clear bit shows on `irq` and at word 0x18 in the next cycle. A decode error shows as a wrong value in the read sweep over all 1024 words.

// File: rtl/sec_counter_alarm.sv
module sec_counter_alarm #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 12,
  parameter logic [63:0] ID_BYTES = 64'hB1_05_F0_0D_00_18_10_31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] WA_COUNT = 'd0;
  localparam logic [WA_W-1:0] WA_MATCH = 'd1;
  localparam logic [WA_W-1:0] WA_LOAD  = 'd2;
  localparam logic [WA_W-1:0] WA_CTRL  = 'd3;
  localparam logic [WA_W-1:0] WA_MASK  = 'd4;
  localparam logic [WA_W-1:0] WA_RAW   = 'd5;
  localparam logic [WA_W-1:0] WA_MIS   = 'd6;
  localparam logic [WA_W-1:0] WA_CLR   = 'd7;
  localparam logic [WA_W-1:0] WA_ID    = WA_W'(12'hFE0 >> 2);

  logic [WA_W-1:0]   wa;
  logic [DATA_W-1:0] count_q, match_q, load_q, count_d, match_d;
  logic              raw_q, mask_q, hit;
  logic              wr_load, wr_match, wr_mask, wr_clr;
  logic [2:0]        id_idx;

  assign wa       = addr[ADDR_W-1:2];
  assign wr_load  = wr_en && (wa == WA_LOAD);
  assign wr_match = wr_en && (wa == WA_MATCH);
  assign wr_mask  = wr_en && (wa == WA_MASK);
  assign wr_clr   = wr_en && (wa == WA_CLR);

  assign count_d = wr_load ? wdata : (tick ? count_q + 1'b1 : count_q);
  assign match_d = wr_match ? wdata : match_q;
  assign hit     = (wr_load || tick || wr_match) && (count_d == match_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      match_q <= '0;
      load_q  <= '0;
      raw_q   <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      count_q <= count_d;
      match_q <= match_d;
      if (wr_load) load_q <= wdata;
      if (wr_mask) mask_q <= wdata[0];
      if (wr_clr)   raw_q <= 1'b0;
      else if (hit) raw_q <= 1'b1;
    end
  end

  assign irq    = raw_q & mask_q;
  assign id_idx = wa[2:0];

  always_comb begin
    rdata = '0;
    if (wa >= WA_ID) begin
      rdata[7:0] = ID_BYTES[8*id_idx +: 8];
    end else begin
      case (wa)
        WA_COUNT: rdata = count_q;
        WA_MATCH: rdata = match_q;
        WA_LOAD:  rdata = load_q;
        WA_CTRL:  rdata[0] = 1'b1;
        WA_MASK:  rdata[0] = mask_q;
        WA_RAW:   rdata[0] = raw_q;
        WA_MIS:   rdata[0] = irq;
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_counter_alarm_checks.sv
module sec_counter_alarm_checks #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [11:0]       addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] match_q,
  input logic              raw_q
);
  logic w_load, w_match, w_mask, w_clr;
  assign w_load  = wr_en && (addr[11:2] == 10'd2);
  assign w_match = wr_en && (addr[11:2] == 10'd1);
  assign w_mask  = wr_en && (addr[11:2] == 10'd4);
  assign w_clr   = wr_en && (addr[11:2] == 10'd7);

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !w_load |=> count_q == $past(count_q) + 1'b1); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> count_q == $past(wdata)); // R2
  AST_RAW_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> count_q == match_q); // R4
  AST_MATCH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    w_match && !tick && wdata == count_q |=> raw_q); // R6
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    w_mask && !wdata[0] |=> !irq); // R7
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    w_clr |=> !raw_q); // R8
endmodule

bind sec_counter_alarm sec_counter_alarm_checks #(.DATA_W(DATA_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .irq(irq), .count_q(count_q), .match_q(match_q), .raw_q(raw_q)
);

// File: tb/test_sec_counter_alarm.sv
`timescale 1ns/100ps
module test_sec_counter_alarm;
  localparam logic [63:0] ID = 64'h0D_F0_AD_BA_31_10_41_00;

  logic        clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, v;
  logic        irq;
  int          n_run = 0, n_fail = 0;

  sec_counter_alarm #(.ID_BYTES(ID)) i_sec_counter_alarm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; tick = tk;
    @(negedge clk);
    wr_en = 0; tick = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] exp_word(input int w);
    if (w >= 'h3F8) return {24'h0, ID[8*(w-'h3F8) +: 8]};
    case (w)
      0, 1, 2: return 32'h00C0FFEE;
      3, 4, 5, 6: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(12'h000, v); chk("R1 reset count", v, 0);
    rd(12'h004, v); chk("R3 reset match", v, 0);
    rd(12'h008, v); chk("R2 reset load", v, 0);
    rd(12'h014, v); chk("R4 reset raw", v, 0);
    chk("R7 reset irq", {31'b0, irq}, 0);
    rd(12'h00C, v); chk("R9 ctrl", v, 1);

    wr(12'h008, 32'hFFFF_FFF0, 0);
    rd(12'h008, v); chk("R2 load readback", v, 32'hFFFF_FFF0);
    for (int k = 1; k <= 20; k++) begin
      pulse();
      rd(12'h000, v); chk("R1 tick count wrap", v, 32'hFFFF_FFF0 + k);
    end
    wr(12'h008, 32'h0000_1000, 1);
    rd(12'h000, v); chk("R2 load beats tick", v, 32'h1000);

    wr(12'h004, 32'hA5A5_0001, 0);
    rd(12'h004, v); chk("R3 match rw", v, 32'hA5A5_0001);
    wr(12'h004, 32'h5A5A_FFFE, 0);
    rd(12'h004, v); chk("R3 match rw", v, 32'h5A5A_FFFE);

    wr(12'h010, 32'h1, 0);
    for (int b = 0; b < 2; b++) begin
      for (int d = 0; d <= 5; d++) begin
        logic [31:0] base;
        base = (b == 0) ? 32'hFFFF_FFFD : 32'h0000_0100;
        wr(12'h008, 32'h1234_5678, 0);
        wr(12'h004, base + d, 0);
        wr(12'h01C, 32'h0, 0);
        wr(12'h008, base, 0);
        for (int k = 0; k <= 6; k++) begin
          if (k > 0) pulse();
          rd(12'h000, v); chk("R1 count in sweep", v, base + k);
          rd(12'h014, v); chk("R4 R5 raw at distance", v, (k >= d) ? 1 : 0);
          rd(12'h018, v); chk("R7 masked status", v, (k >= d) ? 1 : 0);
          chk("R7 irq", {31'b0, irq}, (k >= d) ? 1 : 0);
        end
      end
    end

    wr(12'h008, 32'd500, 0);
    wr(12'h01C, 32'h0, 0);
    wr(12'h004, 32'd501, 0);
    rd(12'h014, v); chk("R6 unequal match no set", v, 0);
    wr(12'h004, 32'd500, 0);
    rd(12'h014, v); chk("R6 equal match sets now", v, 1);

    wr(12'h010, 32'hFFFF_FFFE, 0);
    rd(12'h010, v); chk("R7 mask bit0 only", v, 0);
    chk("R7 irq masked", {31'b0, irq}, 0);
    rd(12'h018, v); chk("R7 mis masked", v, 0);
    wr(12'h010, 32'h3, 0);
    rd(12'h010, v); chk("R7 mask set", v, 1);
    chk("R7 irq unmasked", {31'b0, irq}, 1);

    wr(12'h01C, 32'h0, 0);
    rd(12'h014, v); chk("R8 clear data 0", v, 0);
    wr(12'h004, 32'd500, 0);
    wr(12'h01C, 32'hFFFF_FFFF, 0);
    rd(12'h014, v); chk("R8 clear data ones", v, 0);
    wr(12'h008, 32'd999, 0);
    wr(12'h004, 32'd1000, 0);
    wr(12'h01C, 32'h0, 1);
    rd(12'h000, v); chk("R8 tick during clear", v, 1000);
    rd(12'h014, v); chk("R8 clear beats match", v, 0);
    chk("R8 irq after clear", {31'b0, irq}, 0);

    wr(12'h00C, 32'h0, 0);
    rd(12'h00C, v); chk("R9 ctrl write ignored", v, 1);
    rd(12'h000, v); chk("R9 count unaffected", v, 1000);
    rd(12'h004, v); chk("R9 match unaffected", v, 1000);

    for (int w = 0; w < 8; w++)
      for (int o = 0; o < 4; o++) begin
        rd(12'hFE0 + 12'(4*w + o), v);
        chk("R10 id byte", v, {24'h0, ID[8*w +: 8]});
      end

    wr(12'h008, 32'h00C0_FFEE, 0);
    wr(12'h004, 32'h00C0_FFEE, 0);
    for (int w = 0; w < 1024; w++) begin
      rd(12'(4*w + (w % 4)), v);
      chk("R11 read sweep", v, exp_word(w));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule